// File: doc/BRIEF.md
# Pin Control Register Bank

This block holds the configuration of up to 32 device pins behind a simple register bus. Each pin owns one 32-bit control word. The word carries the pin's function select, its pull, slew, filter, open-drain and drive options, an interrupt configuration nibble and an interrupt flag. Every configuration field drives a dedicated parallel output, so the pad ring and the pin multiplexer can use them directly.

Two broadcast registers write the same 16-bit configuration into the lower half of many pin words in a single bus write. The upper half of the broadcast value is a per-pin enable mask. Each pin word has a lock bit. Once the lock bit is set, the lower half of that word is frozen until reset, whether the write is direct or broadcast.

Interrupt flags are set by an external edge/level detector through `evt_set`. Software clears them with write-one-to-clear, either through the pin word or through a collected flag register.

Top module: `pcr_bank`

## Requirements
- R1: After reset every pin word reads 0. All configuration outputs and flags are 0, so every pin comes up disabled (function select 0), unlocked, with interrupts off.
- R2: A write with `bus_addr` = 4*n (n < 32) reaches pin word n. Its fields are:
  - bit 0 pull select, bit 1 pull enable, bit 2 slew, bit 4 passive filter
  - bit 5 open drain, bit 6 drive strength
  - bits 10:8 function select (0 disabled/analog, 1 GPIO, 2..7 alternates)
  - bit 15 lock, bits 19:16 interrupt configuration, bit 24 interrupt flag

  The word reads back with these fields, and each field appears on its output one cycle after the write.
- R3: Bits 3, 7, 14:11, 23:20 and 31:25 of every pin word always read 0, and writes to them are ignored.
- R4: A write to 0x80 places bits 15:0 of the written value (masked as in R3) into bits 15:0 of pin k, for every k in 0..15 whose bit 16+k is 1. Bits 31:16 of those words are unchanged.
- R5: A write to 0x84 does the same for pin 16+k, enabled by bit 16+k of the written value.
- R6: Reads of 0x80 and 0x84 return 0.
- R7: While bit 15 of a pin word is 1, bits 15:0 of that word ignore direct and broadcast writes until reset. Bits 19:16 stay writable and the flag can still be cleared.
- R8: The flag of pin n becomes 1 one cycle after `evt_set[n]` is high. Writing 1 to bit 24 of pin word n clears it, and writing 0 there has no effect. A set and a clear in the same cycle leave the flag at 1.
- R9: A read of 0xA0 returns the flag of pin n in bit n. Writing 1 to bit n of 0xA0 clears flag n.
- R10: Addresses outside the map, and any address with bits 1:0 not 00, read 0 and change nothing on write.
- R11: `bus_rdata` is 0 whenever the cycle is not a read (`bus_en` low or `bus_we` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| evt_set | input | 32 | Per-pin interrupt event, sets the flag |
| pin_mux | output | 96 | Function select, 3 bits per pin |
| pin_pull_sel | output | 32 | Pull direction per pin |
| pin_pull_en | output | 32 | Pull enable per pin |
| pin_slew | output | 32 | Slew control per pin |
| pin_pfilt | output | 32 | Passive filter enable per pin |
| pin_odrain | output | 32 | Open-drain enable per pin |
| pin_drive | output | 32 | Drive strength per pin |
| pin_irq_cfg | output | 128 | Interrupt configuration, 4 bits per pin |
| pin_irq_flag | output | 32 | Interrupt flag per pin |

## Verification
The assertions assume that `evt_set` and the bus inputs change only away from the rising clock edge. They also assume that reset is released only between edges, so the lock and flag properties can compare each edge with the one before it. The bench holds to this by driving every input on the falling edge. It deasserts reset there as well and keeps reset low for several edges, so that no property sees the state left over from before reset. Flag-set events are kept sparse during the random phase, so that the clear paths are exercised while flags are still high.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned HALF_W   = 16;

   // field positions inside one pin word
   localparam int unsigned B_PULL_SEL = 0;
   localparam int unsigned B_PULL_EN  = 1;
   localparam int unsigned B_SLEW     = 2;
   localparam int unsigned B_PFILT    = 4;
   localparam int unsigned B_ODRAIN   = 5;
   localparam int unsigned B_DRIVE    = 6;
   localparam int unsigned B_MUX_LO   = 8;
   localparam int unsigned MUX_W      = 3;
   localparam int unsigned B_LOCK     = 15;
   localparam int unsigned B_IRQ_LO   = 16;
   localparam int unsigned IRQ_W      = 4;
   localparam int unsigned B_FLAG     = 24;

   // implemented bits of the lower half, with and without the lock bit
   localparam logic [HALF_W-1:0] LOW_MASK_LK = 16'h8777;
   localparam logic [HALF_W-1:0] LOW_MASK_NL = 16'h0777;

   // word indices (byte address >> 2) of the shared registers
   localparam int unsigned WIDX_BCAST_LO = 32;
   localparam int unsigned WIDX_BCAST_HI = 33;
   localparam int unsigned WIDX_FLAGS    = 40;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PIN,
      SEL_BC_LO,
      SEL_BC_HI,
      SEL_FLAGS
   } sel_e;

   typedef struct packed {
      logic              flag;
      logic [IRQ_W-1:0]  irq;
      logic [HALF_W-1:0] low;
   } pin_state_t;

   function automatic logic [WORD_W-1:0] pack_word(input pin_state_t s);
      logic [WORD_W-1:0] w;
      w = '0;
      w[HALF_W-1:0]              = s.low;
      w[B_IRQ_LO +: IRQ_W]       = s.irq;
      w[B_FLAG]                  = s.flag;
      return w;
   endfunction

endpackage

// File: rtl/pcr_addr_dec.sv
module pcr_addr_dec
   import pcr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned IDX_W    = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output logic [IDX_W-1:0]  pin_idx
);

   localparam int unsigned WA_W = ADDR_W - 2;
   localparam logic [WA_W-1:0] PIN_LIM = WA_W'(NUM_PINS);
   localparam logic [WA_W-1:0] IX_BLO  = WA_W'(WIDX_BCAST_LO);
   localparam logic [WA_W-1:0] IX_BHI  = WA_W'(WIDX_BCAST_HI);
   localparam logic [WA_W-1:0] IX_FLG  = WA_W'(WIDX_FLAGS);

   logic [WA_W-1:0] widx;
   logic            aligned;

   assign widx    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign pin_idx = widx[IDX_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (aligned) begin
         if (widx < PIN_LIM)       sel = SEL_PIN;
         else if (widx == IX_BLO)  sel = SEL_BC_LO;
         else if (widx == IX_BHI)  sel = SEL_BC_HI;
         else if (widx == IX_FLG)  sel = SEL_FLAGS;
      end
   end

endmodule

// File: rtl/pcr_pin_word.sv
module pcr_pin_word
   import pcr_pkg::*;
#(
   parameter bit LOCKABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_we,
   input  logic              bc_we,
   input  logic [HALF_W-1:0] wr_low,
   input  logic [IRQ_W-1:0]  wr_irq,
   input  logic [HALF_W-1:0] bc_low,
   input  logic              flag_clr,
   input  logic              flag_set,
   output pin_state_t        state
);

   logic              frozen;
   logic [HALF_W-1:0] low_mask;

   generate
      if (LOCKABLE) begin : g_lock
         assign frozen   = state.low[B_LOCK];
         assign low_mask = LOW_MASK_LK;
      end else begin : g_nolock
         assign frozen   = 1'b0;
         assign low_mask = LOW_MASK_NL;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '0;
      end else begin
         if (dir_we && !frozen) begin
            state.low <= wr_low & low_mask;
         end else if (bc_we && !frozen) begin
            state.low <= bc_low & low_mask;
         end
         if (dir_we) begin
            state.irq <= wr_irq;
         end
         if (flag_set) begin
            state.flag <= 1'b1;
         end else if (flag_clr) begin
            state.flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pcr_rd_mux.sv
module pcr_rd_mux
   import pcr_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned IDX_W    = 5
) (
   input  logic                       rd_en,
   input  sel_e                       sel,
   input  logic [IDX_W-1:0]           pin_idx,
   input  logic [NUM_PINS*WORD_W-1:0] words,
   input  logic [NUM_PINS-1:0]        flags,
   output logic [WORD_W-1:0]          rdata
);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            SEL_PIN:   rdata = words[pin_idx*WORD_W +: WORD_W];
            SEL_FLAGS: rdata[NUM_PINS-1:0] = flags;
            default:   rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
   import pcr_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter bit          LOCKABLE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_en,
   input  logic                      bus_we,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [WORD_W-1:0]         bus_wdata,
   output logic [WORD_W-1:0]         bus_rdata,
   input  logic [NUM_PINS-1:0]       evt_set,
   output logic [NUM_PINS*MUX_W-1:0] pin_mux,
   output logic [NUM_PINS-1:0]       pin_pull_sel,
   output logic [NUM_PINS-1:0]       pin_pull_en,
   output logic [NUM_PINS-1:0]       pin_slew,
   output logic [NUM_PINS-1:0]       pin_pfilt,
   output logic [NUM_PINS-1:0]       pin_odrain,
   output logic [NUM_PINS-1:0]       pin_drive,
   output logic [NUM_PINS*IRQ_W-1:0] pin_irq_cfg,
   output logic [NUM_PINS-1:0]       pin_irq_flag
);

   localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   generate
      if (NUM_PINS < 2 || NUM_PINS > 32) begin : g_bad_pins
         $error("pcr_bank: NUM_PINS must lie in 2..32");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("pcr_bank: ADDR_W must be at least 8");
      end
   endgenerate

   sel_e                       sel;
   logic [IDX_W-1:0]           pin_idx;
   logic                       wr;
   logic                       rd;
   logic [NUM_PINS*WORD_W-1:0] word_flat;
   logic [NUM_PINS-1:0]        flag_vec;

   assign wr = bus_en && bus_we;
   assign rd = bus_en && !bus_we;

   pcr_addr_dec #(
      .ADDR_W  (ADDR_W),
      .NUM_PINS(NUM_PINS),
      .IDX_W   (IDX_W)
   ) u_dec (
      .addr   (bus_addr),
      .sel    (sel),
      .pin_idx(pin_idx)
   );

   genvar p;
   generate
      for (p = 0; p < NUM_PINS; p++) begin : g_pin
         logic       hit;
         logic       dir_we;
         logic       bc_we;
         logic       flag_clr;
         pin_state_t st;

         assign hit    = (sel == SEL_PIN) && (pin_idx == IDX_W'(p));
         assign dir_we = wr && hit;

         if (p < HALF_W) begin : g_lo_half
            assign bc_we = wr && (sel == SEL_BC_LO) && bus_wdata[HALF_W + p];
         end else begin : g_hi_half
            assign bc_we = wr && (sel == SEL_BC_HI) && bus_wdata[p];
         end

         assign flag_clr = wr && ((hit && bus_wdata[B_FLAG]) ||
                                  ((sel == SEL_FLAGS) && bus_wdata[p]));

         pcr_pin_word #(
            .LOCKABLE(LOCKABLE)
         ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_we  (dir_we),
            .bc_we   (bc_we),
            .wr_low  (bus_wdata[HALF_W-1:0]),
            .wr_irq  (bus_wdata[B_IRQ_LO +: IRQ_W]),
            .bc_low  (bus_wdata[HALF_W-1:0]),
            .flag_clr(flag_clr),
            .flag_set(evt_set[p]),
            .state   (st)
         );

         assign word_flat[p*WORD_W +: WORD_W] = pack_word(st);
         assign flag_vec[p]                   = st.flag;

         assign pin_mux[p*MUX_W +: MUX_W]     = st.low[B_MUX_LO +: MUX_W];
         assign pin_pull_sel[p]               = st.low[B_PULL_SEL];
         assign pin_pull_en[p]                = st.low[B_PULL_EN];
         assign pin_slew[p]                   = st.low[B_SLEW];
         assign pin_pfilt[p]                  = st.low[B_PFILT];
         assign pin_odrain[p]                 = st.low[B_ODRAIN];
         assign pin_drive[p]                  = st.low[B_DRIVE];
         assign pin_irq_cfg[p*IRQ_W +: IRQ_W] = st.irq;
      end
   endgenerate

   assign pin_irq_flag = flag_vec;

   pcr_rd_mux #(
      .NUM_PINS(NUM_PINS),
      .IDX_W   (IDX_W)
   ) u_rd (
      .rd_en  (rd),
      .sel    (sel),
      .pin_idx(pin_idx),
      .words  (word_flat),
      .flags  (flag_vec),
      .rdata  (bus_rdata)
   );

endmodule

// File: rtl/pcr_bank_chk.sv
module pcr_bank_chk #(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_en,
   input logic                   bus_we,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [31:0]            bus_rdata,
   input logic [NUM_PINS-1:0]    evt_set,
   input logic [NUM_PINS-1:0]    pin_irq_flag,
   input logic [NUM_PINS*32-1:0] word_flat
);

   localparam logic [31:0] USED_BITS = 32'h010F_8777;

   logic                rd;
   logic                pin_rd;
   logic [NUM_PINS-1:0] lock_v;

   assign rd     = bus_en && !bus_we;
   assign pin_rd = rd && (bus_addr[1:0] == 2'b00) && (32'(bus_addr >> 2) < NUM_PINS);

   always_comb begin
      for (int k = 0; k < NUM_PINS; k++) begin
         lock_v[k] = word_flat[k*32 + 15];
      end
   end

   // R7: a lock never drops outside reset
   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lock_v) & ~lock_v) == '0);

   genvar p;
   generate
      for (p = 0; p < NUM_PINS; p++) begin : g_frz
         // R7: locked lower half holds its value
         a_r7_low_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            word_flat[p*32 + 15] |=> word_flat[p*32 +: 16] == $past(word_flat[p*32 +: 16]));
      end
   endgenerate

   // R3: stored words carry no reserved bits
   a_r3_word_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (word_flat & ~{NUM_PINS{USED_BITS}}) == '0);

   // R3: pin reads show no reserved bits
   a_r3_read_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rd |-> (bus_rdata & ~USED_BITS) == 32'h0);

   // R6: broadcast registers read as zero
   a_r6_bcast_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (32'(bus_addr) == 32'h80 || 32'(bus_addr) == 32'h84)) |-> bus_rdata == 32'h0);

   // R8: an event sets its flag on the next edge
   a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> (pin_irq_flag & $past(evt_set)) == $past(evt_set));

   // R8: a flag only rises because of an event
   a_r8_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_irq_flag & ~$past(pin_irq_flag) & ~$past(evt_set)) == '0);

   // R10: unaligned reads return zero
   a_r10_unaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);

   // R11: no read, no data
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> bus_rdata == 32'h0);

endmodule

bind pcr_bank pcr_bank_chk #(
   .NUM_PINS(NUM_PINS),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_en      (bus_en),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_rdata   (bus_rdata),
   .evt_set     (evt_set),
   .pin_irq_flag(pin_irq_flag),
   .word_flat   (word_flat)
);

// File: tb/pcr_bank_tb.sv
module pcr_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] evt_set = '0;
   logic [NP*3-1:0] pin_mux;
   logic [NP-1:0] pin_pull_sel, pin_pull_en, pin_slew, pin_pfilt;
   logic [NP-1:0] pin_odrain, pin_drive, pin_irq_flag;
   logic [NP*4-1:0] pin_irq_cfg;

   pcr_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_set(evt_set), .pin_mux(pin_mux), .pin_pull_sel(pin_pull_sel),
      .pin_pull_en(pin_pull_en), .pin_slew(pin_slew), .pin_pfilt(pin_pfilt),
      .pin_odrain(pin_odrain), .pin_drive(pin_drive),
      .pin_irq_cfg(pin_irq_cfg), .pin_irq_flag(pin_irq_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] mw [NP];
   int n_vec = 0;
   int n_bad = 0;

   function automatic logic [31:0] m_read(logic en, logic we, logic [7:0] a);
      logic [31:0] v;
      v = '0;
      if (!en || we || a[1:0] != 2'b00) return v;
      if (int'(a[7:2]) < NP) return mw[a[7:2]];
      if (a == 8'hA0) begin
         for (int k = 0; k < NP; k++) v[k] = mw[k][24];
      end
      return v;
   endfunction

   task automatic m_update(logic en, logic we, logic [7:0] a, logic [31:0] d, logic [NP-1:0] ev);
      if (en && we && a[1:0] == 2'b00) begin
         if (int'(a[7:2]) < NP) begin
            int n = int'(a[7:2]);
            if (!mw[n][15]) mw[n][15:0] = d[15:0] & 16'h8777;
            mw[n][19:16] = d[19:16];
            if (d[24]) mw[n][24] = 1'b0;
         end else if (a == 8'h80 || a == 8'h84) begin
            for (int k = 0; k < 16; k++) begin
               int n = (a == 8'h80) ? k : k + 16;
               if (d[16+k] && !mw[n][15]) mw[n][15:0] = d[15:0] & 16'h8777;
            end
         end else if (a == 8'hA0) begin
            for (int k = 0; k < NP; k++) if (d[k]) mw[k][24] = 1'b0;
         end
      end
      for (int k = 0; k < NP; k++) if (ev[k]) mw[k][24] = 1'b1;
   endtask

   task automatic check(string tag);
      logic [31:0] er;
      logic [NP*3-1:0] emux;
      logic [NP*4-1:0] eirq;
      logic [NP-1:0] ps, pe, sl, pf, od, dr, fl;
      er = m_read(bus_en, bus_we, bus_addr);
      for (int k = 0; k < NP; k++) begin
         emux[k*3 +: 3] = mw[k][10:8];
         eirq[k*4 +: 4] = mw[k][19:16];
         ps[k] = mw[k][0]; pe[k] = mw[k][1]; sl[k] = mw[k][2];
         pf[k] = mw[k][4]; od[k] = mw[k][5]; dr[k] = mw[k][6];
         fl[k] = mw[k][24];
      end
      n_vec++;
      if (bus_rdata !== er) begin
         n_bad++;
         $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, er);
      end
      if (pin_mux !== emux || pin_irq_cfg !== eirq || pin_pull_sel !== ps ||
          pin_pull_en !== pe || pin_slew !== sl || pin_pfilt !== pf ||
          pin_odrain !== od || pin_drive !== dr || pin_irq_flag !== fl) begin
         n_bad++;
         $display("FAIL %s outputs actual mux=%h irq=%h flag=%h expected mux=%h irq=%h flag=%h",
                  tag, pin_mux, pin_irq_cfg, pin_irq_flag, emux, eirq, fl);
      end
   endtask

   task automatic step(logic en, logic we, logic [7:0] a, logic [31:0] d,
                       logic [NP-1:0] ev, string tag);
      @(negedge clk);
      bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; evt_set = ev;
      #1;
      check(tag);
      @(posedge clk);
      m_update(en, we, a, d, ev);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
      step(1'b1, 1'b1, a, d, '0, tag);
   endtask

   task automatic rd(logic [7:0] a, string tag);
      step(1'b1, 1'b0, a, 32'h0, '0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_en = 1'b0; bus_we = 1'b0; evt_set = '0;
      for (int k = 0; k < NP; k++) mw[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      do_reset();
      // R1: reset state of every word and the shared registers
      for (int k = 0; k < NP; k++) rd(8'(k*4), "R1");
      rd(8'h80, "R6"); rd(8'h84, "R6"); rd(8'hA0, "R9");

      // R2 / R3: all ones to pin 3, reserved bits must vanish, lock sets
      wr(8'h0C, 32'hFFFF_FFFF, "R3");
      rd(8'h0C, "R3");
      // R7: locked pin keeps lower half, upper nibble changes
      wr(8'h0C, 32'h0005_0000, "R7");
      rd(8'h0C, "R7");

      // R2: several patterns with each function select value
      for (int k = 0; k < 8; k++) wr(8'(k*4 + 32), {12'h0, 4'(k), 5'h0, 3'(k), 8'(8'h11*k) & 8'h77}, "R2");
      for (int k = 8; k < 16; k++) rd(8'(k*4), "R2");

      // R4 / R7: broadcast low half, pin 3 is locked
      wr(8'h80, 32'h00AD_0123, "R4");
      for (int k = 0; k < 8; k++) rd(8'(k*4), "R4");
      // R5: broadcast high half to pins 16 and 31
      wr(8'h84, 32'h8001_0205, "R5");
      rd(8'h40, "R5"); rd(8'h7C, "R5"); rd(8'h44, "R5"); rd(8'h84, "R6");

      // R8 / R9: flags set, read, cleared
      step(1'b0, 1'b0, 8'h00, 32'h0, 32'h8001_0002, "R8");
      rd(8'hA0, "R9");
      wr(8'h04, 32'h0000_0000, "R8");
      rd(8'hA0, "R8");
      wr(8'h04, 32'h0100_0000, "R8");
      wr(8'hA0, 32'h8000_0000, "R9");
      rd(8'hA0, "R9");
      step(1'b1, 1'b1, 8'h40, 32'h0100_0000, 32'h0001_0000, "R8");
      rd(8'hA0, "R8");
      // R7: flag clear on a locked pin
      step(1'b0, 1'b0, 8'h00, 32'h0, 32'h0000_0008, "R7");
      wr(8'h0C, 32'h0100_0000, "R7");
      rd(8'h0C, "R7");

      // R10: unmapped and unaligned
      wr(8'h88, 32'hFFFF_FFFF, "R10");
      wr(8'hC0, 32'hFFFF_FFFF, "R10");
      wr(8'h21, 32'h0000_0201, "R10");
      rd(8'h20, "R10"); rd(8'h0D, "R10"); rd(8'hFC, "R10");

      // R11: no read, no data
      step(1'b0, 1'b0, 8'h0C, 32'h0, '0, "R11");
      step(1'b1, 1'b1, 8'h20, 32'h0000_0301, '0, "R11");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         int sel = $urandom % 10;
         logic [7:0] a;
         logic [31:0] d = $urandom;
         logic [NP-1:0] ev = '0;
         if ($urandom % 8 != 0) d[15] = 1'b0;
         case (sel)
            6: a = 8'h80;
            7: a = 8'h84;
            8: a = 8'hA0;
            9: a = 8'($urandom);
            default: a = 8'(($urandom % NP) * 4);
         endcase
         if ($urandom % 12 == 0) ev[$urandom % NP] = 1'b1;
         step(($urandom % 10) != 0, $urandom % 2 == 0, a, d, ev, "R2");
      end

      // R1: second reset clears locks and flags
      do_reset();
      for (int k = 0; k < NP; k++) rd(8'(k*4), "R1");
      wr(8'h0C, 32'h0000_0100, "R1");
      rd(8'h0C, "R1");

      finish_run();
   end

endmodule